// File: doc/BRIEF.md
# Scatter-Gather Chain Walker

This block walks a list of transfer descriptors held in memory and issues one memory request per 32-bit word of payload. A start pulse supplies the memory address of the first descriptor and a direction bit. Each descriptor takes two consecutive words. The first word holds a word count in its low bits and a "more follows" flag in its top bit. The second word holds the byte address where the payload for that descriptor begins.

The walker reads a descriptor and then steps through the payload addresses, 4 bytes at a time, until the count is used up. If the flag is set it fetches the next descriptor; if not, it finishes. At the end it pulses `done` and reports the total number of payload words it moved. A descriptor whose count is above the per-entry limit stops the walk with an `err` pulse. So does a chain that asks for more entries than the limit allows. The disk data path and its buffering are outside this block: it produces only the address sequence and the write enable.

Top module: `sg_chain_walker`

## Requirements
- R1: After reset the walker is idle: `busy`, `mem_req`, `done` and `err` are low and `total_words` is 0. No request is issued while idle.
- R2: A `start` pulse while idle latches `chain_base` and `dir`. The first descriptor is fetched as a count word at `chain_base` and then an address word at `chain_base`+4. Each later descriptor follows at the next 8-byte step.
- R3: In a count word, bit 31 set means another descriptor follows. Bits 30:0 are the word count.
- R4: Payload requests for a descriptor with count N and address A go to A, A+4, …, A+4(N-1), in that order. `mem_we` is 1 for payload when `dir`=0 (disk to memory) and 0 when `dir`=1. Descriptor fetches always have `mem_we`=0.
- R5: A request is accepted in a cycle where `mem_req` and `mem_ready` are both high. While `mem_ready` is low, the request, its address and its write enable hold unchanged.
- R6: A descriptor with count 0 causes no payload request. The walk continues according to its flag.
- R7: `done` is high for exactly one cycle, the cycle after the final request is accepted. At that point `total_words` equals the sum of all counts. `total_words` then holds until the next accepted start.
- R8: A count above MAX_WORDS (default 16384) raises a one-cycle `err` in the cycle after that count word is accepted. No payload request is made for that descriptor, and no further fetch follows. A count of exactly MAX_WORDS completes normally.
- R9: If a descriptor flagged "more follows" is the MAX_ENTRIES-th (default 33) of the chain, `err` pulses once its payload is finished. No fetch is made for the extra descriptor.
- R10: A `start` pulse while busy is ignored. The walk in progress continues with its original base and direction.
- R11: `done` and `err` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (honoured only when idle) |
| dir | input | 1 | 0: payload written to memory; 1: payload read from memory |
| chain_base | input | AW | Byte address of the first descriptor |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Request byte address |
| mem_ready | input | 1 | Memory accepts the current request |
| mem_rdata | input | DW | Read data, valid with `mem_ready` for reads |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle error pulse |
| total_words | output | TW | Payload words moved in the current or last walk |

## Verification
The hardest case to reach from the ports is the entry-limit error. It needs a chain of 34 linked descriptors in which every one of the first 33 completes normally. The error must also come without any access to the 34th. The bench builds such chains in its memory model from a count pattern that includes zero-length entries, and runs them under random back-pressure. It counts descriptor fetches separately from payload accesses, which shows that the walk stops exactly after 66 descriptor words. The exact-limit and just-over-limit counts are each driven by a directed single-entry chain, and one over-limit case comes after a valid first entry.

// File: rtl/sgw_pkg.sv
package sgw_pkg;

   typedef enum logic [2:0] {
      SG_IDLE,
      SG_CNT,
      SG_ADR,
      SG_XFER,
      SG_DONE,
      SG_ERR
   } sg_state_e;

endpackage

// File: rtl/sgw_ctrl.sv
module sgw_ctrl
   import sgw_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start,
   input  logic      accept,
   input  logic      over,
   input  logic      cnt_zero,
   input  logic      cnt_last,
   input  logic      more,
   input  logic      at_max,
   output sg_state_e st
);

   sg_state_e st_nx;
   sg_state_e after_entry;

   always_comb begin
      if (!more)
         after_entry = SG_DONE;
      else if (at_max)
         after_entry = SG_ERR;
      else
         after_entry = SG_CNT;
   end

   always_comb begin
      st_nx = st;
      unique case (st)
         SG_IDLE: if (start) st_nx = SG_CNT;
         SG_CNT:  if (accept) st_nx = over ? SG_ERR : SG_ADR;
         SG_ADR:  if (accept) st_nx = cnt_zero ? after_entry : SG_XFER;
         SG_XFER: if (accept && cnt_last) st_nx = after_entry;
         SG_DONE: st_nx = SG_IDLE;
         SG_ERR:  st_nx = SG_IDLE;
         default: st_nx = SG_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= SG_IDLE;
      else        st <= st_nx;
   end

endmodule

// File: rtl/sgw_datapath.sv
module sgw_datapath
   import sgw_pkg::*;
#(
   parameter int AW          = 32,
   parameter int DW          = 32,
   parameter int MAX_ENTRIES = 33,
   parameter int MAX_WORDS   = 16384,
   localparam int CW = $clog2(MAX_WORDS + 1),
   localparam int IW = $clog2(MAX_ENTRIES + 1),
   localparam int TW = $clog2(MAX_ENTRIES * MAX_WORDS + 1)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  sg_state_e     st,
   input  logic          start,
   input  logic          dir,
   input  logic [AW-1:0] chain_base,
   input  logic          accept,
   input  logic [DW-1:0] rdata,
   output logic [AW-1:0] mem_addr,
   output logic          mem_we,
   output logic          over,
   output logic          cnt_zero,
   output logic          cnt_last,
   output logic          more,
   output logic          at_max,
   output logic [TW-1:0] total
);

   localparam logic [DW-2:0] WLIM = (DW-1)'(MAX_WORDS);
   localparam logic [AW-1:0] STEP = AW'(4);

   logic [AW-1:0] ptr, xaddr;
   logic [CW-1:0] cnt;
   logic [IW-1:0] idx;
   logic          dir_q;

   wire load    = (st == SG_IDLE) && start;
   wire cnt_acc = (st == SG_CNT)  && accept;
   wire adr_acc = (st == SG_ADR)  && accept;
   wire dat_acc = (st == SG_XFER) && accept;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr   <= '0;
         xaddr <= '0;
         cnt   <= '0;
         idx   <= '0;
         more  <= 1'b0;
         dir_q <= 1'b0;
         total <= '0;
      end else begin
         if (load) begin
            ptr   <= chain_base;
            idx   <= '0;
            total <= '0;
            dir_q <= dir;
         end
         if (cnt_acc) begin
            cnt  <= rdata[CW-1:0];
            more <= rdata[DW-1];
            ptr  <= ptr + STEP;
            idx  <= idx + IW'(1);
         end
         if (adr_acc) begin
            xaddr <= rdata[AW-1:0];
            ptr   <= ptr + STEP;
         end
         if (dat_acc) begin
            xaddr <= xaddr + STEP;
            cnt   <= cnt - CW'(1);
            total <= total + TW'(1);
         end
      end
   end

   assign over     = rdata[DW-2:0] > WLIM;
   assign cnt_zero = (cnt == '0);
   assign cnt_last = (cnt == CW'(1));
   assign at_max   = (idx == IW'(MAX_ENTRIES));
   assign mem_addr = (st == SG_XFER) ? xaddr : ptr;
   assign mem_we   = (st == SG_XFER) && !dir_q;

endmodule

// File: rtl/sg_chain_walker.sv
module sg_chain_walker
   import sgw_pkg::*;
#(
   parameter int AW          = 32,
   parameter int DW          = 32,
   parameter int MAX_ENTRIES = 33,
   parameter int MAX_WORDS   = 16384,
   localparam int TW = $clog2(MAX_ENTRIES * MAX_WORDS + 1)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          dir,
   input  logic [AW-1:0] chain_base,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   input  logic          mem_ready,
   input  logic [DW-1:0] mem_rdata,
   output logic          busy,
   output logic          done,
   output logic          err,
   output logic [TW-1:0] total_words
);

   if (DW != 32) begin : g_bad_dw
      $error("sg_chain_walker: descriptor words must be 32 bits");
   end
   if (AW > DW || AW < 3) begin : g_bad_aw
      $error("sg_chain_walker: AW must lie in 3..DW");
   end
   if (MAX_ENTRIES < 1 || MAX_WORDS < 1 || MAX_WORDS >= (1 << 30)) begin : g_bad_lim
      $error("sg_chain_walker: limit parameters out of range");
   end

   sg_state_e st;
   logic      over, cnt_zero, cnt_last, more, at_max;
   logic      accept;

   assign mem_req = (st == SG_CNT) || (st == SG_ADR) || (st == SG_XFER);
   assign accept  = mem_req && mem_ready;
   assign busy    = (st != SG_IDLE);
   assign done    = (st == SG_DONE);
   assign err     = (st == SG_ERR);

   sgw_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .accept   (accept),
      .over     (over),
      .cnt_zero (cnt_zero),
      .cnt_last (cnt_last),
      .more     (more),
      .at_max   (at_max),
      .st       (st)
   );

   sgw_datapath #(
      .AW          (AW),
      .DW          (DW),
      .MAX_ENTRIES (MAX_ENTRIES),
      .MAX_WORDS   (MAX_WORDS)
   ) u_dp (
      .clk        (clk),
      .rst_n      (rst_n),
      .st         (st),
      .start      (start),
      .dir        (dir),
      .chain_base (chain_base),
      .accept     (accept),
      .rdata      (mem_rdata),
      .mem_addr   (mem_addr),
      .mem_we     (mem_we),
      .over       (over),
      .cnt_zero   (cnt_zero),
      .cnt_last   (cnt_last),
      .more       (more),
      .at_max     (at_max),
      .total      (total_words)
   );

endmodule

// File: rtl/sgw_checker.sv
module sgw_checker #(
   parameter int AW          = 32,
   parameter int MAX_ENTRIES = 33,
   parameter int MAX_WORDS   = 16384,
   localparam int TW = $clog2(MAX_ENTRIES * MAX_WORDS + 1)
)(
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          busy,
   input logic          mem_req,
   input logic          mem_ready,
   input logic          mem_we,
   input logic [AW-1:0] mem_addr,
   input logic          done,
   input logic          err,
   input logic [TW-1:0] total_words
);

   localparam logic [TW-1:0] TMAX = TW'(MAX_ENTRIES * MAX_WORDS);

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req);                                        // R1
   AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);                                 // R2
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R5
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                            // R7
   AST_TOTAL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(total_words));                // R7
   AST_TOTAL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      total_words <= TMAX);                                       // R7
   AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> !err);                                              // R11
   AST_END_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && err));                                            // R11

endmodule

bind sg_chain_walker sgw_checker #(
   .AW          (AW),
   .MAX_ENTRIES (MAX_ENTRIES),
   .MAX_WORDS   (MAX_WORDS)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .busy        (busy),
   .mem_req     (mem_req),
   .mem_ready   (mem_ready),
   .mem_we      (mem_we),
   .mem_addr    (mem_addr),
   .done        (done),
   .err         (err),
   .total_words (total_words)
);

// File: tb/tb_sg_chain_walker.sv
module tb_sg_chain_walker;

   localparam int TW   = $clog2(33 * 16384 + 1);
   localparam logic [31:0] DBASE = 32'h0000_0100;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic          start = 1'b0, dir = 1'b0;
   logic [31:0]   chain_base = '0;
   logic          mem_req, mem_we, mem_ready, busy, done, err;
   logic [31:0]   mem_addr, mem_rdata;
   logic [TW-1:0] total_words;

   always #2 clk = ~clk;

   sg_chain_walker dut (
      .clk(clk), .rst_n(rst_n), .start(start), .dir(dir), .chain_base(chain_base),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_ready(mem_ready),
      .mem_rdata(mem_rdata), .busy(busy), .done(done), .err(err), .total_words(total_words)
   );

   // memory model: descriptors at DBASE, payload space elsewhere
   logic [31:0] desc_mem [0:127];
   int          cnt_arr  [0:39];
   logic [31:0] adr_arr  [0:39];
   int          n_ent;
   logic [31:0] off;

   always_comb begin
      off = mem_addr - DBASE;
      if (mem_addr >= DBASE && mem_addr < DBASE + 32'd512)
         mem_rdata = desc_mem[off[8:2]];
      else
         mem_rdata = 32'hFFFF_FFFF;
   end

   logic [7:0] lfsr = 8'h5A;
   logic       stall_en = 1'b0;
   always @(posedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
   assign mem_ready = !stall_en || lfsr[2];

   // monitor
   int          n_chk = 0, n_fail = 0;
   int          n_desc, n_data, bad_desc, bad_data, bad_we;
   int          mon_e, mon_off;
   logic        cur_dir;
   logic [31:0] cur_base, exp_a;

   always @(negedge clk) begin
      if (rst_n && mem_req && mem_ready) begin
         if (mem_addr < 32'h0001_0000) begin
            if (mem_addr != cur_base + 32'(4 * n_desc)) bad_desc++;
            if (mem_we) bad_we++;
            n_desc++;
         end else begin
            while (mon_e < n_ent && mon_off >= cnt_arr[mon_e]) begin
               mon_e++;
               mon_off = 0;
            end
            exp_a = adr_arr[mon_e] + 32'(4 * mon_off);
            if (mem_addr != exp_a) bad_data++;
            if (mem_we != !cur_dir) bad_we++;
            mon_off++;
            n_data++;
         end
      end
   end

   task automatic chk(input string r, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", r, act, exp);
      end
   endtask

   task automatic put(input int i, input bit mr, input int c, input logic [31:0] a);
      desc_mem[2*i]   = {mr, 31'(c)};
      desc_mem[2*i+1] = a;
      cnt_arr[i] = c;
      adr_arr[i] = a;
   endtask

   task automatic run(input logic d, input logic stl, input bit exp_err,
                      input int exp_total, input int exp_desc, input int exp_data,
                      input bit poke);
      int t;
      n_desc = 0; n_data = 0; bad_desc = 0; bad_data = 0; bad_we = 0;
      mon_e = 0; mon_off = 0; cur_dir = d; cur_base = DBASE; stall_en = stl;
      @(negedge clk);
      start = 1'b1; dir = d; chain_base = DBASE;
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         repeat (3) @(negedge clk);
         start = 1'b1; dir = ~d; chain_base = 32'h0;   // R10 ignored while busy
         @(negedge clk);
         start = 1'b0; dir = d;
      end
      t = 0;
      while (!(done || err) && t < 100000) begin
         @(negedge clk);
         t++;
      end
      chk("R7/R8/R9 done", done, !exp_err);
      chk("R8/R9 err", err, exp_err);
      if (!exp_err) chk("R7 total_words", total_words, exp_total);
      chk("R2/R9 descriptor fetches", n_desc, exp_desc);
      chk("R4/R6/R8 payload accesses", n_data, exp_data);
      chk("R2 descriptor addresses", bad_desc, 0);
      chk("R4 payload addresses", bad_data, 0);
      chk("R4 write enable", bad_we, 0);
      @(negedge clk);
      chk("R11 single-cycle end pulse", done | err, 0);
      if (!exp_err) chk("R7 total held", total_words, exp_total);
   endtask

   typedef struct packed {
      logic [7:0] n;
      logic [7:0] c0;
      logic [7:0] step;
      logic       d;
      logic       stl;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{8'd1,  8'd5, 8'd0, 1'b0, 1'b0},
      '{8'd3,  8'd1, 8'd2, 1'b1, 1'b1},
      '{8'd4,  8'd0, 8'd3, 1'b0, 1'b1},
      '{8'd2,  8'd7, 8'd9, 1'b1, 1'b0},
      '{8'd33, 8'd1, 8'd1, 1'b0, 1'b1},
      '{8'd34, 8'd2, 8'd1, 1'b1, 1'b1}
   };

   task automatic finish_up();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL R7 watchdog: actual no end expected done or err");
      finish_up();
   end

   initial begin
      for (int i = 0; i < 128; i++) desc_mem[i] = '0;
      n_ent = 0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 busy", busy, 0);
      chk("R1 mem_req", mem_req, 0);
      chk("R1 done/err", done | err, 0);
      chk("R1 total_words", total_words, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle after release", mem_req | busy, 0);

      // vector table: R3 flag/count, R4, R5 stalls, R6 zero entries, R9 limit
      for (int v = 0; v < 6; v++) begin
         int n, sum, used;
         n = int'(VECS[v].n);
         used = (n > 33) ? 33 : n;
         sum = 0;
         for (int i = 0; i < n; i++) begin
            int c;
            c = (int'(VECS[v].c0) + int'(VECS[v].step) * i) & 15;
            put(i, i < n - 1, c, 32'h0001_0000 + 32'(i) * 32'h1000);
            if (i < used) sum += c;
         end
         n_ent = n;
         run(VECS[v].d, VECS[v].stl, n > 33, sum, 2 * used, sum, 1'b0);
      end

      // R8 count just over limit: error, no payload
      put(0, 1'b0, 16385, 32'h0002_0000); n_ent = 1;
      run(1'b0, 1'b0, 1'b1, 0, 1, 0, 1'b0);

      // R8 over-limit in second entry after a valid first entry
      put(0, 1'b1, 3, 32'h0003_0000);
      put(1, 1'b0, 20000, 32'h0004_0000); n_ent = 2;
      run(1'b1, 1'b1, 1'b1, 0, 3, 3, 1'b0);

      // R8 exactly at limit completes
      put(0, 1'b0, 16384, 32'h0005_0000); n_ent = 1;
      run(1'b0, 1'b0, 1'b0, 16384, 2, 16384, 1'b0);

      // R10 start while busy ignored
      put(0, 1'b1, 6, 32'h0006_0000);
      put(1, 1'b0, 4, 32'h0007_0000); n_ent = 2;
      run(1'b0, 1'b1, 1'b0, 10, 4, 10, 1'b1);

      finish_up();
   end

endmodule